// File: doc/BRIEF.md
# Data Lane High-Speed Burst Sequencer

This block is the transmit-side control for a single serial data lane that alternates between a low-power signalling mode and a high-speed burst mode. While idle it holds the lane in the stop state. When a payload source raises `in_valid`, it walks the lane through the entry handshake: a low-power request, a low-power prepare, and a high-speed zero period. It then emits a one-cycle sync marker and streams payload bytes through a valid/ready interface. When `in_valid` drops, it drives a trail state, the inverse of the last bit sent, and returns to the stop state. It then holds off the next burst until a minimum exit time has elapsed. The block does not serialise: each cycle it gives a line-state code and, where one applies, a parallel byte for a downstream serialiser and line driver.

Every phase length is a configuration input counted in reference-clock cycles. The sequencer clamps each one into the legal window that the parameters set, so a wrong register value can never produce an illegal prepare, trail or exit time. The lane belongs to a multi-lane group, and it joins a burst only when its index falls within the configured number of active lanes. The group always uses the lowest-numbered lanes.

The sequencer has seven named states. STOP drives stop (LP-11) and waits out the exit time. REQ drives request (LP-01). PREP drives prepare (LP-00). ZERO drives high-speed zero. SYNC drives the marker byte. DATA carries the payload. TRAIL drives the trail state. The transitions are:
- start: STOP→REQ, taken when the exit timer is spent, `in_valid` is high and the lane is active.
- req_done: REQ→PREP.
- prep_done: PREP→ZERO.
- zero_done: ZERO→SYNC.
- sync_sent: SYNC→DATA.
- end_of_data: DATA→TRAIL, taken when `in_valid` is low.
- trail_done: TRAIL→STOP, which reloads the exit timer.

Top module: `lane_burst_seq`

## Requirements
- R1: During and right after reset, the line code is stop (0), `in_ready` is 0 and `tx_vld` is 0.
- R2: A burst starts (STOP→REQ) only when `in_valid` is high, the exit timer is spent, and the lane index LANE_IDX is below `act_lanes`. An inactive lane stays in stop with `in_ready` low however long `in_valid` is held.
- R3: The request code (1) lasts max(`cfg_lpx`,1) cycles, and only the stop code may precede it.
- R4: The prepare code (2) lasts `cfg_prep` clamped into [MIN_PREP, MAX_PREP] cycles, and only the request code may precede it.
- R5: The high-speed zero code (3) before the sync lasts max(`cfg_zero`,1) cycles.
- R6: The sync cycle shows the high-speed data code (5) with `tx_byte`=0xB8, `tx_vld`=1 and `in_ready`=0, for exactly one cycle.
- R7: `in_ready` is high in every cycle of DATA and low in every other state. Each accepted byte appears on `tx_byte` with `tx_vld`=1 and code 5 in the same cycle. The first byte comes in the cycle right after sync.
- R8: The first cycle in DATA with `in_valid` low ends the payload. That cycle already shows the trail code, with `tx_vld`=0.
- R9: The trail code is the inverse of bit 7 of the last byte sent, or of the sync byte when no payload was sent. Bit 1 gives high-speed zero (3) and bit 0 gives high-speed one (4).
- R10: The trail lasts `cfg_trail` clamped into [MIN_TRAIL, MAX_TRAIL] cycles, counted from the cycle named in R8.
- R11: After a trail, stop holds for at least max(`cfg_exit`,MIN_EXIT) cycles. With `in_valid` already high, the next request follows after exactly that many cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| act_lanes | input | $clog2(LANES+1) | Number of active lanes in the group |
| cfg_lpx | input | CFG_W | Request length in cycles |
| cfg_prep | input | CFG_W | Prepare length in cycles, clamped |
| cfg_zero | input | CFG_W | High-speed zero length in cycles |
| cfg_trail | input | CFG_W | Trail length in cycles, clamped |
| cfg_exit | input | CFG_W | Minimum stop time after a burst, clamped from below |
| in_valid | input | 1 | Payload byte valid; its first low in DATA ends the burst |
| in_data | input | 8 | Payload byte, sent least significant bit first |
| in_ready | output | 1 | High in DATA only |
| line_st | output | 3 | Line code: 0 stop, 1 request, 2 prepare, 3 HS zero, 4 HS one, 5 HS data |
| tx_byte | output | 8 | Byte for the serialiser (sync or payload) |
| tx_vld | output | 1 | `tx_byte` holds a byte this cycle |

## Verification
The assertions assume that the configuration inputs change only while the lane is in stop. They also assume `act_lanes` is steady when a burst starts, and that MIN_TRAIL is at least 2. The stimulus changes the configuration and lane count only between bursts, in idle gaps that are either zero cycles or a random few. `in_valid` is never dropped in the middle of a payload except to end it. Random bursts draw every configuration field from its full range, including 0 and the all-ones value, so the clamp bounds are crossed in both directions.

// File: rtl/lbs_pkg.sv
package lbs_pkg;

    // Line codes presented to the serialiser / driver.
    typedef enum logic [2:0] {
        LN_LP11  = 3'd0,
        LN_LP01  = 3'd1,
        LN_LP00  = 3'd2,
        LN_HS0   = 3'd3,
        LN_HS1   = 3'd4,
        LN_HSDAT = 3'd5
    } line_e;

    // Sequencer states.
    typedef enum logic [2:0] {
        ST_STOP  = 3'd0,
        ST_REQ   = 3'd1,
        ST_PREP  = 3'd2,
        ST_ZERO  = 3'd3,
        ST_SYNC  = 3'd4,
        ST_DATA  = 3'd5,
        ST_TRAIL = 3'd6
    } seq_e;

endpackage

// File: rtl/lbs_cfg_clamp.sv
module lbs_cfg_clamp #(
    parameter int W  = 4,
    parameter int LO = 1,
    parameter int HI = 15
) (
    input  logic [W-1:0] raw,
    output logic [W-1:0] eff
);
    localparam logic [W-1:0] LO_V = W'(LO);
    localparam logic [W-1:0] HI_V = W'(HI);

    always_comb begin
        if (raw < LO_V) begin
            eff = LO_V;
        end else if (raw > HI_V) begin
            eff = HI_V;
        end else begin
            eff = raw;
        end
    end
endmodule

// File: rtl/lbs_phase_timer.sv
module lbs_phase_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/lbs_trail_pol.sv
module lbs_trail_pol (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cap_en,
    input  logic       cap_bit,
    output logic [2:0] trail_code
);
    import lbs_pkg::*;

    logic last_bit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_bit <= 1'b0;
        end else if (cap_en) begin
            last_bit <= cap_bit;
        end
    end

    // Drive the opposite differential state of the final serialised bit.
    assign trail_code = last_bit ? LN_HS0 : LN_HS1;
endmodule

// File: rtl/lane_burst_seq.sv
module lane_burst_seq #(
    parameter int          CFG_W     = 4,
    parameter int          LANES     = 4,
    parameter int          LANE_IDX  = 1,
    parameter int          MIN_PREP  = 2,
    parameter int          MAX_PREP  = 5,
    parameter int          MIN_TRAIL = 2,
    parameter int          MAX_TRAIL = 6,
    parameter int          MIN_EXIT  = 3,
    parameter logic [7:0]  SYNC_BYTE = 8'hB8,
    localparam int         LW        = $clog2(LANES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LW-1:0]    act_lanes,
    input  logic [CFG_W-1:0] cfg_lpx,
    input  logic [CFG_W-1:0] cfg_prep,
    input  logic [CFG_W-1:0] cfg_zero,
    input  logic [CFG_W-1:0] cfg_trail,
    input  logic [CFG_W-1:0] cfg_exit,
    input  logic             in_valid,
    input  logic [7:0]       in_data,
    output logic             in_ready,
    output logic [2:0]       line_st,
    output logic [7:0]       tx_byte,
    output logic             tx_vld
);
    import lbs_pkg::*;

    localparam int               CFG_MAX = (1 << CFG_W) - 1;
    localparam logic [CFG_W-1:0] ONE     = CFG_W'(1);
    localparam logic [CFG_W-1:0] TWO     = CFG_W'(2);
    localparam logic [LW-1:0]    MY_IDX  = LW'(LANE_IDX);

    seq_e             state, state_nxt;
    logic             tmr_load, tmr_done;
    logic [CFG_W-1:0] tmr_val;
    logic [CFG_W-1:0] lpx_eff, prep_eff, zero_eff, trail_eff, exit_eff;
    logic             cap_en, cap_bit;
    logic [2:0]       trail_code;
    logic             lane_on;

    assign lane_on = (MY_IDX < act_lanes);

    // Legal windows for every phase length.
    lbs_cfg_clamp #(.W(CFG_W), .LO(1),         .HI(CFG_MAX))   u_cl_lpx (.raw(cfg_lpx),   .eff(lpx_eff));
    lbs_cfg_clamp #(.W(CFG_W), .LO(MIN_PREP),  .HI(MAX_PREP))  u_cl_prp (.raw(cfg_prep),  .eff(prep_eff));
    lbs_cfg_clamp #(.W(CFG_W), .LO(1),         .HI(CFG_MAX))   u_cl_zro (.raw(cfg_zero),  .eff(zero_eff));
    lbs_cfg_clamp #(.W(CFG_W), .LO(MIN_TRAIL), .HI(MAX_TRAIL)) u_cl_trl (.raw(cfg_trail), .eff(trail_eff));
    lbs_cfg_clamp #(.W(CFG_W), .LO(MIN_EXIT),  .HI(CFG_MAX))   u_cl_ext (.raw(cfg_exit),  .eff(exit_eff));

    lbs_phase_timer #(.W(CFG_W)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    lbs_trail_pol u_pol (
        .clk        (clk),
        .rst_n      (rst_n),
        .cap_en     (cap_en),
        .cap_bit    (cap_bit),
        .trail_code (trail_code)
    );

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_STOP;
        end else begin
            state <= state_nxt;
        end
    end

    // Transitions and timer loads.
    always_comb begin
        state_nxt = state;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        unique case (state)
            ST_STOP: begin
                if (tmr_done && in_valid && lane_on) begin      // start
                    state_nxt = ST_REQ;
                    tmr_load  = 1'b1;
                    tmr_val   = lpx_eff - ONE;
                end
            end
            ST_REQ: begin
                if (tmr_done) begin                              // req_done
                    state_nxt = ST_PREP;
                    tmr_load  = 1'b1;
                    tmr_val   = prep_eff - ONE;
                end
            end
            ST_PREP: begin
                if (tmr_done) begin                              // prep_done
                    state_nxt = ST_ZERO;
                    tmr_load  = 1'b1;
                    tmr_val   = zero_eff - ONE;
                end
            end
            ST_ZERO: begin
                if (tmr_done) begin                              // zero_done
                    state_nxt = ST_SYNC;
                end
            end
            ST_SYNC: begin
                state_nxt = ST_DATA;                             // sync_sent
            end
            ST_DATA: begin
                if (!in_valid) begin                             // end_of_data
                    state_nxt = ST_TRAIL;
                    tmr_load  = 1'b1;
                    tmr_val   = trail_eff - TWO;                 // this cycle is trail cycle 1
                end
            end
            ST_TRAIL: begin
                if (tmr_done) begin                              // trail_done
                    state_nxt = ST_STOP;
                    tmr_load  = 1'b1;
                    tmr_val   = exit_eff - ONE;
                end
            end
            default: begin
                state_nxt = ST_STOP;
            end
        endcase
    end

    // Outputs.
    always_comb begin
        line_st  = LN_LP11;
        in_ready = 1'b0;
        tx_byte  = 8'h00;
        tx_vld   = 1'b0;
        cap_en   = 1'b0;
        cap_bit  = 1'b0;
        unique case (state)
            ST_STOP:  line_st = LN_LP11;
            ST_REQ:   line_st = LN_LP01;
            ST_PREP:  line_st = LN_LP00;
            ST_ZERO:  line_st = LN_HS0;
            ST_SYNC: begin
                line_st = LN_HSDAT;
                tx_byte = SYNC_BYTE;
                tx_vld  = 1'b1;
                cap_en  = 1'b1;
                cap_bit = SYNC_BYTE[7];
            end
            ST_DATA: begin
                in_ready = 1'b1;
                if (in_valid) begin
                    line_st = LN_HSDAT;
                    tx_byte = in_data;
                    tx_vld  = 1'b1;
                    cap_en  = 1'b1;
                    cap_bit = in_data[7];
                end else begin
                    line_st = trail_code;
                end
            end
            ST_TRAIL: line_st = trail_code;
            default:  line_st = LN_LP11;
        endcase
    end
endmodule

// File: rtl/lbs_chk.sv
module lbs_chk #(
    parameter int MIN_EXIT  = 3,
    parameter int MAX_TRAIL = 6
) (
    input logic       clk,
    input logic       rst_n,
    input logic       in_valid,
    input logic       in_ready,
    input logic [2:0] line_st,
    input logic       tx_vld
);
    import lbs_pkg::*;

    logic       after_data, seen_burst, in_trail;
    logic [7:0] trail_run, lp11_run;

    assign in_trail = after_data && (line_st == LN_HS0 || line_st == LN_HS1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            after_data <= 1'b0;
            seen_burst <= 1'b0;
            trail_run  <= '0;
            lp11_run   <= '0;
        end else begin
            if (tx_vld) begin
                after_data <= 1'b1;
                seen_burst <= 1'b1;
            end else if (line_st == LN_LP11) begin
                after_data <= 1'b0;
            end
            trail_run <= in_trail ? ((trail_run == 8'hFF) ? trail_run : trail_run + 8'd1) : 8'd0;
            lp11_run  <= (line_st == LN_LP11) ? ((lp11_run == 8'hFF) ? lp11_run : lp11_run + 8'd1) : 8'd0;
        end
    end

    assert_ready_payload_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && in_valid) |-> (line_st == LN_HSDAT));

    assert_byte_hs_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tx_vld |-> (line_st == LN_HSDAT));

    assert_start_from_stop_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (line_st == LN_LP01 && $past(line_st) != LN_LP01) |-> ($past(line_st) == LN_LP11));

    assert_req_to_prep_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (line_st == LN_LP01) |=> (line_st == LN_LP01 || line_st == LN_LP00));

    assert_prep_to_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (line_st == LN_LP00) |=> (line_st == LN_LP00 || line_st == LN_HS0));

    assert_trail_bounded_R10: assert property (@(posedge clk) disable iff (!rst_n)
        in_trail |-> (trail_run < 8'(MAX_TRAIL)));

    assert_exit_time_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (line_st == LN_LP01 && seen_burst && lp11_run != 8'd0) |-> (lp11_run >= 8'(MIN_EXIT)));
endmodule

bind lane_burst_seq lbs_chk #(
    .MIN_EXIT  (MIN_EXIT),
    .MAX_TRAIL (MAX_TRAIL)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .line_st  (line_st),
    .tx_vld   (tx_vld)
);

// File: tb/sim_lane_burst_seq.sv
module sim_lane_burst_seq;
    import lbs_pkg::*;

    localparam int CFG_W = 4, LANES = 4, LANE_IDX = 1;
    localparam int MIN_PREP = 2, MAX_PREP = 5, MIN_TRAIL = 2, MAX_TRAIL = 6, MIN_EXIT = 3;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic             rst_n;
    logic [2:0]       act_lanes;
    logic [CFG_W-1:0] cfg_lpx, cfg_prep, cfg_zero, cfg_trail, cfg_exit;
    logic             in_valid, in_ready, tx_vld;
    logic [7:0]       in_data, tx_byte;
    logic [2:0]       line_st;

    lane_burst_seq #(
        .CFG_W(CFG_W), .LANES(LANES), .LANE_IDX(LANE_IDX),
        .MIN_PREP(MIN_PREP), .MAX_PREP(MAX_PREP),
        .MIN_TRAIL(MIN_TRAIL), .MAX_TRAIL(MAX_TRAIL), .MIN_EXIT(MIN_EXIT)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .act_lanes(act_lanes),
        .cfg_lpx(cfg_lpx), .cfg_prep(cfg_prep), .cfg_zero(cfg_zero),
        .cfg_trail(cfg_trail), .cfg_exit(cfg_exit),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .line_st(line_st), .tx_byte(tx_byte), .tx_vld(tx_vld)
    );

    int checks = 0, failures = 0;
    int e_prev = 0, idle_k = 0;
    logic [7:0]  pay   [0:15];
    logic [12:0] rec   [0:511];   // {code, vld, rdy, byte}
    logic [2:0]  rcode [0:511];

    function automatic int lo1(int v);
        return (v < 1) ? 1 : v;
    endfunction
    function automatic int clampv(int v, int lo, int hi);
        return (v < lo) ? lo : ((v > hi) ? hi : v);
    endfunction
    function automatic int maxi(int a, int b);
        return (a > b) ? a : b;
    endfunction

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic idle(int k);
        in_valid = 1'b0;
        repeat (k) @(negedge clk);
        idle_k += k;
    endtask

    task automatic set_cfg(int l, int p, int z, int t, int e);
        cfg_lpx = CFG_W'(l); cfg_prep = CFG_W'(p); cfg_zero = CFG_W'(z);
        cfg_trail = CFG_W'(t); cfg_exit = CFG_W'(e);
    endtask

    task automatic burst(int n, string tag);
        int len, idx, p, cnt, exp_w, tcode, rdy_bad;
        bit started;
        len = 0; idx = 0; started = 0;
        exp_w = maxi(e_prev - 1 - idle_k, 1);
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            in_valid = started ? (idx < n) : 1'b1;
            in_data  = (idx < n) ? pay[idx] : 8'h00;
            #1;
            rcode[len] = line_st;
            rec[len]   = {line_st, tx_vld, in_ready, tx_byte};
            len++;
            if (in_valid && in_ready) idx++;
            if (line_st != 3'(LN_LP11)) started = 1;
            else if (started) break;
        end
        in_valid = 1'b0;
        rdy_bad = 0;
        p = 0;
        cnt = 0; while (p < len && rcode[p] == 3'(LN_LP11)) begin cnt++; p++; end
        chk("R11/R2", {tag, " stop cycles before request"}, cnt, exp_w);
        cnt = 0; while (p < len && rcode[p] == 3'(LN_LP01)) begin cnt++; rdy_bad += int'(rec[p][8]); p++; end
        chk("R3", {tag, " request cycles"}, cnt, lo1(int'(cfg_lpx)));
        cnt = 0; while (p < len && rcode[p] == 3'(LN_LP00)) begin cnt++; rdy_bad += int'(rec[p][8]); p++; end
        chk("R4", {tag, " prepare cycles"}, cnt, clampv(int'(cfg_prep), MIN_PREP, MAX_PREP));
        cnt = 0; while (p < len && rcode[p] == 3'(LN_HS0)) begin cnt++; rdy_bad += int'(rec[p][8]); p++; end
        chk("R5", {tag, " zero cycles"}, cnt, lo1(int'(cfg_zero)));
        chk("R6", {tag, " sync cycle"}, int'(rec[p]), int'({3'(LN_HSDAT), 1'b1, 1'b0, 8'hB8}));
        p++;
        for (int i = 0; i < n; i++) begin
            chk("R7", {tag, " payload cycle"}, int'(rec[p]), int'({3'(LN_HSDAT), 1'b1, 1'b1, pay[i]}));
            p++;
        end
        tcode = ((n > 0) ? pay[n-1][7] : 1'b1) ? int'(LN_HS0) : int'(LN_HS1);
        chk("R8", {tag, " end-of-data cycle"}, int'(rec[p][12:8]), (tcode << 2) | 1);
        chk("R9", {tag, " trail code"}, int'(rcode[p]), tcode);
        cnt = 0;
        while (p < len && int'(rcode[p]) == tcode) begin
            if (cnt > 0) rdy_bad += int'(rec[p][8]);
            cnt++; p++;
        end
        chk("R10", {tag, " trail cycles"}, cnt, clampv(int'(cfg_trail), MIN_TRAIL, MAX_TRAIL));
        chk("R7", {tag, " ready outside payload"}, rdy_bad, 0);
        chk("R11", {tag, " back to stop"}, (p < len) ? int'(rcode[p]) : -1, int'(LN_LP11));
        e_prev = maxi(int'(cfg_exit), MIN_EXIT);
        idle_k = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int bad;
        void'($urandom(32'h1a2b3c));
        rst_n = 1'b0; act_lanes = 3'd4; in_valid = 1'b0; in_data = 8'h00;
        set_cfg(2, 3, 2, 3, 4);
        repeat (3) @(negedge clk);
        #1;
        chk("R1", "reset outputs {code,rdy,vld}", int'({line_st, in_ready, tx_vld}), 0);
        @(negedge clk); rst_n = 1'b1;
        #1;
        chk("R1", "post-reset outputs {code,rdy,vld}", int'({line_st, in_ready, tx_vld}), 0);

        // Inactive lane: index 1 with only one active lane.
        act_lanes = 3'd1; in_valid = 1'b1; bad = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk); #1;
            if (line_st != 3'(LN_LP11) || in_ready) bad++;
        end
        chk("R2", "inactive lane left stop", bad, 0);
        act_lanes = 3'd2;
        idle(2);

        // Directed bursts.
        pay[0] = 8'h12; pay[1] = 8'hF0; pay[2] = 8'h35;
        burst(3, "basic");                                  // last bit 0 -> HS1 trail
        pay[0] = 8'h80;
        burst(1, "back-to-back");                           // last bit 1 -> HS0 trail
        burst(0, "no-payload");                             // trail from sync byte
        idle(1);
        set_cfg(0, 0, 0, 0, 0);                             // lower clamps
        burst(2, "low-clamp");
        set_cfg(15, 15, 15, 15, 15);                        // upper clamps
        burst(4, "high-clamp");
        idle(20);
        set_cfg(1, 4, 1, 2, 3);
        burst(1, "after-long-idle");

        // Random bursts.
        for (int b = 0; b < 40; b++) begin
            int n, k;
            n = $urandom_range(0, 8);
            k = $urandom_range(0, 4);
            for (int i = 0; i < n; i++) pay[i] = 8'($urandom);
            set_cfg($urandom_range(0, 15), $urandom_range(0, 15), $urandom_range(0, 15),
                    $urandom_range(0, 15), $urandom_range(0, 15));
            idle(k);
            burst(n, "random");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule